// File: doc/BRIEF.md
# Shift and Rotate Execute Unit

This block is the shift stage of a 64-bit RISC execute pipeline. Each accepted operation names an instruction form through a small class code and carries the 32-bit instruction word. It also carries the register operand to be shifted and a second register that holds a variable shift amount. The unit decodes the amount and the exact operation from these inputs. It then computes a left shift, a logical right shift, an arithmetic right shift or a rotate right, in either a 32-bit word form or a 64-bit doubleword form.

Logical right shift and rotate right share one class code. A five-bit selector field inside the instruction word chooses between them: a value of 0 selects the shift and a value of 1 selects the rotate. Any other selector value is reserved and raises an exception flag. An unknown class code raises the same flag. Results appear one cycle after the valid strobe. Word results are always sign-extended from bit 31 to the full 64 bits.

Top module: `shx_unit`

## Requirements
- R1: After reset, out_valid and rsvd_exc are 0 and result is all zeros.
- R2: out_valid equals in_valid of the previous cycle. When in_valid is low, result holds its value and rsvd_exc is 0 in the following cycle.
- R3: Word forms act on src[31:0]. Left shift fills with zeros, logical right shift fills with zeros and arithmetic right shift copies bit 31. The 32-bit outcome is sign-extended to 64 bits.
- R4: Word rotate right gives (w >> n) | (w << (32 - n)) on the low 32 bits, sign-extended to 64 bits.
- R5: A rotate (word or doubleword) by an amount of zero returns the operand unchanged (word: sign-extended low half).
- R6: Doubleword forms shift or rotate all 64 bits of src. Doubleword rotate gives (x >> n) | (x << (64 - n)).
- R7: The "plus 32" doubleword forms (class codes 9, 10, 11) use 32 plus instr[10:6] as the amount, which ranges from 32 to 63.
- R8: Immediate forms take their amount from instr[10:6], which is 0 to 31. Variable word forms use shamt_reg[4:0] and variable doubleword forms use shamt_reg[5:0]. All other bits of shamt_reg are ignored.
- R9: For the immediate right-logical class codes 1, 7 and 10, instr[25:21] selects the operation: 0 gives a logical right shift, 1 gives a rotate right, and any other value raises rsvd_exc.
- R10: For the variable right-logical class codes 4 and 13, instr[10:6] selects the operation: 0 gives a logical right shift, 1 gives a rotate right, and any other value raises rsvd_exc.
- R11: Class codes are 0 SLL word imm, 1 SRL/ROTR word imm, 2 SRA word imm, 3 SLL word var, 4 SRL/ROTR word var, 5 SRA word var, 6 SLL dword imm, 7 SRL/ROTR dword imm, 8 SRA dword imm, 9 SLL dword +32, 10 SRL/ROTR dword +32, 11 SRA dword +32, 12 SLL dword var, 13 SRL/ROTR dword var and 14 SRA dword var. Code 15 raises rsvd_exc.
- R12: When an accepted operation raises rsvd_exc, out_valid still pulses with the flag and result keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op_class | input | 4 | Instruction form code |
| instr | input | 32 | Instruction word (amount and selector fields) |
| src | input | 64 | Operand to shift or rotate |
| shamt_reg | input | 64 | Register holding the variable shift amount |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 64 | Registered shift or rotate result |
| rsvd_exc | output | 1 | Reserved-instruction exception flag |

## Verification
The bench drives rotates by zero. A design that forces that result to zero, or that overflows the 32 - n complement, gives a zero or corrupted value instead of the operand. It drives word operands with bit 31 set, so a missing sign extension or a wrong arithmetic fill shows up in the upper half. Selector values of 2 and above, together with class code 15, must trap without changing the result; a decoder that only tests the low selector bit would quietly rotate instead. Upper bits are set in shamt_reg and in the amount field to catch amount masks of the wrong width, and the plus-32 forms are run at both ends of their range.

// File: rtl/shx_pkg.sv
package shx_pkg;
  localparam int XLEN   = 64;
  localparam int WLEN   = 32;
  localparam int AMT_W  = $clog2(XLEN);
  localparam int WAMT_W = $clog2(WLEN);
  localparam int CLS_W  = 4;

  typedef enum logic [CLS_W-1:0] {
    C_SLL_WI  = 4'd0,  C_SRL_WI  = 4'd1,  C_SRA_WI  = 4'd2,
    C_SLL_WV  = 4'd3,  C_SRL_WV  = 4'd4,  C_SRA_WV  = 4'd5,
    C_SLL_DI  = 4'd6,  C_SRL_DI  = 4'd7,  C_SRA_DI  = 4'd8,
    C_SLL_D32 = 4'd9,  C_SRL_D32 = 4'd10, C_SRA_D32 = 4'd11,
    C_SLL_DV  = 4'd12, C_SRL_DV  = 4'd13, C_SRA_DV  = 4'd14,
    C_BAD     = 4'd15
  } op_cls_e;

  typedef enum logic [1:0] { K_SLL, K_SRL, K_SRA, K_ROR } sh_kind_e;

  typedef struct packed {
    sh_kind_e          kind;
    logic              dword;
    logic [AMT_W-1:0]  amt;
    logic              illegal;
  } sh_op_t;

  // Word-wide operation, sign-extended to XLEN.
  function automatic logic [XLEN-1:0] f_word(sh_kind_e k, logic [WAMT_W-1:0] n,
                                             logic [WLEN-1:0] w);
    logic [WLEN-1:0] r;
    case (k)
      K_SLL:   r = w << n;
      K_SRL:   r = w >> n;
      K_SRA:   r = $unsigned($signed(w) >>> n);
      default: r = (w >> n) | (w << (WLEN[AMT_W:0] - {1'b0, n}));
    endcase
    return {{(XLEN-WLEN){r[WLEN-1]}}, r};
  endfunction

  // Full-width operation.
  function automatic logic [XLEN-1:0] f_dword(sh_kind_e k, logic [AMT_W-1:0] n,
                                              logic [XLEN-1:0] x);
    case (k)
      K_SLL:   return x << n;
      K_SRL:   return x >> n;
      K_SRA:   return $unsigned($signed(x) >>> n);
      default: return (x >> n) | (x << ((AMT_W+1)'(XLEN) - {1'b0, n}));
    endcase
  endfunction
endpackage

// File: rtl/shx_decode.sv
module shx_decode
  import shx_pkg::*;
(
  input  logic [CLS_W-1:0] op_class,
  input  logic [31:0]      instr,
  input  logic [XLEN-1:0]  shamt_reg,
  output sh_op_t           op
);
  localparam int SEL_W = 5;

  logic [SEL_W-1:0]  imm_sel;
  logic [SEL_W-1:0]  var_sel;
  logic [WAMT_W-1:0] imm_amt;

  assign imm_sel = instr[25:21];
  assign var_sel = instr[10:6];
  assign imm_amt = instr[10:6];

  // Right-logical selector: 0 -> shift, 1 -> rotate, else trap.
  function automatic logic [2:0] f_rsel(logic [SEL_W-1:0] s);
    if (s == '0)            return {1'b0, K_SRL};
    else if (s == SEL_W'(1)) return {1'b0, K_ROR};
    else                    return {1'b1, K_SRL};
  endfunction

  always_comb begin
    logic [2:0] sel;
    op.kind    = K_SLL;
    op.dword   = 1'b0;
    op.amt     = '0;
    op.illegal = 1'b0;
    sel        = '0;
    case (op_cls_e'(op_class))
      C_SLL_WI:  begin op.kind = K_SLL; op.amt = {1'b0, imm_amt}; end
      C_SRA_WI:  begin op.kind = K_SRA; op.amt = {1'b0, imm_amt}; end
      C_SRL_WI:  begin
        sel = f_rsel(imm_sel);
        op.kind = sh_kind_e'(sel[1:0]); op.illegal = sel[2];
        op.amt = {1'b0, imm_amt};
      end
      C_SLL_WV:  begin op.kind = K_SLL; op.amt = {1'b0, shamt_reg[WAMT_W-1:0]}; end
      C_SRA_WV:  begin op.kind = K_SRA; op.amt = {1'b0, shamt_reg[WAMT_W-1:0]}; end
      C_SRL_WV:  begin
        sel = f_rsel(var_sel);
        op.kind = sh_kind_e'(sel[1:0]); op.illegal = sel[2];
        op.amt = {1'b0, shamt_reg[WAMT_W-1:0]};
      end
      C_SLL_DI:  begin op.dword = 1'b1; op.kind = K_SLL; op.amt = {1'b0, imm_amt}; end
      C_SRA_DI:  begin op.dword = 1'b1; op.kind = K_SRA; op.amt = {1'b0, imm_amt}; end
      C_SRL_DI:  begin
        sel = f_rsel(imm_sel);
        op.dword = 1'b1; op.kind = sh_kind_e'(sel[1:0]); op.illegal = sel[2];
        op.amt = {1'b0, imm_amt};
      end
      C_SLL_D32: begin op.dword = 1'b1; op.kind = K_SLL; op.amt = {1'b1, imm_amt}; end
      C_SRA_D32: begin op.dword = 1'b1; op.kind = K_SRA; op.amt = {1'b1, imm_amt}; end
      C_SRL_D32: begin
        sel = f_rsel(imm_sel);
        op.dword = 1'b1; op.kind = sh_kind_e'(sel[1:0]); op.illegal = sel[2];
        op.amt = {1'b1, imm_amt};
      end
      C_SLL_DV:  begin op.dword = 1'b1; op.kind = K_SLL; op.amt = shamt_reg[AMT_W-1:0]; end
      C_SRA_DV:  begin op.dword = 1'b1; op.kind = K_SRA; op.amt = shamt_reg[AMT_W-1:0]; end
      C_SRL_DV:  begin
        sel = f_rsel(var_sel);
        op.dword = 1'b1; op.kind = sh_kind_e'(sel[1:0]); op.illegal = sel[2];
        op.amt = shamt_reg[AMT_W-1:0];
      end
      default:   op.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/shx_core.sv
module shx_core
  import shx_pkg::*;
(
  input  sh_op_t          op,
  input  logic [XLEN-1:0] src,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] word_res;
  logic [XLEN-1:0] dword_res;

  assign word_res  = f_word(op.kind, op.amt[WAMT_W-1:0], src[WLEN-1:0]);
  assign dword_res = f_dword(op.kind, op.amt, src);
  assign res       = op.dword ? dword_res : word_res;
endmodule

// File: rtl/shx_unit.sv
module shx_unit
  import shx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CLS_W-1:0]  op_class,
  input  logic [31:0]       instr,
  input  logic [XLEN-1:0]   src,
  input  logic [XLEN-1:0]   shamt_reg,
  output logic              out_valid,
  output logic [XLEN-1:0]   result,
  output logic              rsvd_exc
);
  sh_op_t          dec_op;
  logic            dec_illegal;
  logic [XLEN-1:0] core_res;
  logic            take_res;

  shx_decode u_dec (.op_class(op_class), .instr(instr), .shamt_reg(shamt_reg), .op(dec_op));
  shx_core   u_core (.op(dec_op), .src(src), .res(core_res));

  assign dec_illegal = dec_op.illegal;
  assign take_res    = in_valid && !dec_illegal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      rsvd_exc  <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      rsvd_exc  <= in_valid && dec_illegal;
      if (take_res) result <= core_res;
    end
  end
endmodule

// File: rtl/shx_unit_chk.sv
module shx_unit_chk
  import shx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [CLS_W-1:0] op_class,
  input logic [31:0]      instr,
  input logic [XLEN-1:0]  src,
  input logic             out_valid,
  input logic [XLEN-1:0]  result,
  input logic             rsvd_exc,
  input logic             dec_illegal
);
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !rsvd_exc && $stable(result));
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && dec_illegal |=> rsvd_exc && out_valid && $stable(result));
  a_r11_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_class == 4'd15 |=> rsvd_exc);
  a_r9_selector: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op_class == 4'd1 || op_class == 4'd7 || op_class == 4'd10)
      && instr[25:22] != 4'd0 |=> rsvd_exc);
  a_r10_selector: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op_class == 4'd4 || op_class == 4'd13)
      && instr[10:7] != 4'd0 |=> rsvd_exc);
  a_r5_rot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_class == 4'd7 && instr[25:21] == 5'd1 && instr[10:6] == 5'd0
      |=> result == $past(src));
  a_r12_flag_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_exc |-> out_valid);
endmodule

bind shx_unit shx_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class),
  .instr(instr), .src(src), .out_valid(out_valid), .result(result),
  .rsvd_exc(rsvd_exc), .dec_illegal(dec_illegal)
);

// File: tb/shx_unit_tb.sv
module shx_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op_class = '0;
  logic [31:0] instr = '0;
  logic [63:0] src = '0;
  logic [63:0] shamt_reg = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        rsvd_exc;

  int checks = 0;
  int fails = 0;
  logic [63:0] exp_res = '0;

  always #4 clk = ~clk;

  shx_unit u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class),
    .instr(instr), .src(src), .shamt_reg(shamt_reg), .out_valid(out_valid),
    .result(result), .rsvd_exc(rsvd_exc));

  // Reference model built bit by bit; returns {illegal, value}.
  function automatic logic [64:0] model(int cls, logic [31:0] ins, logic [63:0] a,
                                        logic [63:0] b);
    int op = 0;  // 0 sll, 1 srl, 2 sra, 3 ror
    int n = 0;
    int w = 32;
    logic ill = 1'b0;
    logic [63:0] r = '0;
    int sel;
    if (cls == 15) return {1'b1, 64'd0};
    if (cls >= 6) w = 64;
    case (cls % 3)
      0: op = 0;
      2: op = 2;
      default: begin
        sel = (cls == 4 || cls == 13) ? int'(ins[10:6]) : int'(ins[25:21]);
        if (sel == 0) op = 1; else if (sel == 1) op = 3; else ill = 1'b1;
      end
    endcase
    if (cls == 3 || cls == 4 || cls == 5) n = int'(b[4:0]);
    else if (cls >= 12) n = int'(b[5:0]);
    else if (cls >= 9) n = 32 + int'(ins[10:6]);
    else n = int'(ins[10:6]);
    for (int i = 0; i < w; i++) begin
      case (op)
        0: r[i] = (i >= n) ? a[i-n] : 1'b0;
        1: r[i] = (i + n < w) ? a[i+n] : 1'b0;
        2: r[i] = (i + n < w) ? a[i+n] : a[w-1];
        default: r[i] = a[(i+n) % w];
      endcase
    end
    if (w == 32) for (int i = 32; i < 64; i++) r[i] = r[31];
    return {ill, r};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(string req, int cls, logic [31:0] ins, logic [63:0] a, logic [63:0] b);
    logic [64:0] m;
    @(negedge clk);
    in_valid = 1'b1; op_class = 4'(cls); instr = ins; src = a; shamt_reg = b;
    m = model(cls, ins, a, b);
    @(negedge clk);
    in_valid = 1'b0;
    if (!m[64]) exp_res = m[63:0];
    chk({req, " out_valid"}, {63'd0, out_valid}, 64'd1);
    chk({req, " rsvd_exc"}, {63'd0, rsvd_exc}, {63'd0, m[64]});
    chk({req, " result"}, result, exp_res);
  endtask

  function automatic logic [31:0] mk(logic [4:0] hi, logic [4:0] sa);
    return {6'd0, hi, 5'd0, 5'd0, sa, 6'd0};
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R1 rsvd_exc", {63'd0, rsvd_exc}, 64'd0);
    chk("R1 result", result, 64'd0);
    rst_n = 1'b1;

    run("R3 sll word", 0, mk(0, 4), 64'hFFFF_0000_0800_0001, 0);
    run("R3 sra word", 2, mk(0, 8), 64'h0000_0000_8000_0000, 0);
    run("R3 srl word", 1, mk(0, 1), 64'h0000_0000_8000_0000, 0);
    run("R4 rotr word", 1, mk(1, 4), 64'h0000_0000_0000_000F, 0);
    run("R5 rotr word zero", 1, mk(1, 0), 64'h1234_5678_9ABC_DEF0, 0);
    run("R5 rotr dword zero", 7, mk(1, 0), 64'h8123_4567_89AB_CDEF, 0);
    run("R6 rotr dword", 7, mk(1, 31), 64'h0000_0000_0000_0001, 0);
    run("R6 sra dword", 8, mk(0, 3), 64'h8000_0000_0000_0000, 0);
    run("R7 sll +32 min", 9, mk(0, 0), 64'h0000_0000_FFFF_FFFF, 0);
    run("R7 sra +32 max", 11, mk(0, 31), 64'h8000_0000_0000_0000, 0);
    run("R7 rotr +32", 10, mk(1, 0), 64'h0000_0001_0000_0000, 0);
    run("R8 var word mask", 3, 32'd0, 64'd1, 64'hFFFF_FFFF_FFFF_FFE3);
    run("R8 var dword mask", 12, 32'd0, 64'd1, 64'hFFFF_FFFF_FFFF_FFF3);
    run("R8 imm ignores hi", 6, {6'd0, 5'd0, 5'd0, 5'd31, 5'd2, 6'd63}, 64'd1, 0);
    run("R12 prime", 0, mk(0, 0), 64'h0123_4567_89AB_CDEF, 0);
    run("R9 bad selector", 1, mk(2, 3), 64'hFFFF_FFFF_FFFF_FFFF, 0);
    run("R9 bad sel dword", 7, mk(5'h1F, 3), 64'h5, 0);
    run("R10 var rotr", 13, mk(0, 1), 64'h0000_0000_0000_0003, 64'd1);
    run("R10 var srl", 4, mk(0, 0), 64'h0000_0000_8000_0000, 64'd31);
    run("R10 bad var sel", 4, mk(0, 2), 64'hAAAA, 64'd2);
    run("R11 bad code", 15, 32'hFFFF_FFFF, 64'h77, 64'd1);
    run("R11 sra var dword", 14, 32'd0, 64'hF000_0000_0000_0000, 64'd60);

    for (int k = 0; k < 400; k++) begin
      logic [31:0] ins;
      int cls;
      ins = $urandom();
      cls = int'($urandom_range(0, 15));
      if ($urandom_range(0, 3) != 0) ins[25:21] = 5'($urandom_range(0, 1));
      if ((cls == 4 || cls == 13) && $urandom_range(0, 3) != 0)
        ins[10:6] = 5'($urandom_range(0, 1));
      run("R11 random", cls, ins, {$urandom(), $urandom()}, {$urandom(), $urandom()});
    end

    @(negedge clk);
    chk("R2 idle out_valid", {63'd0, out_valid}, 64'd0);
    chk("R2 idle hold", result, exp_res);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule